// File: doc/BRIEF.md
# Linear Pipelined Trie Lookup Engine

This block performs longest-prefix-match route lookups on a leaf-pushed binary trie held across a straight chain of pipeline stages. Every clock it can accept one destination address. Every clock it can also deliver one result. Each result comes out after the same fixed number of cycles, and results leave in the order the addresses arrived. Each stage owns a private node memory with one-cycle synchronous read. Only the request that names a stage as its target reads from that stage's memory.

A lookup starts at the root, which is word 0 of stage 0. It consumes address bits from the most significant end. At an internal node it picks the left child (bit 0) at the stored base word or the right child (bit 1) at base+1. That child lives in the stage named by the node. The named stage may be any later stage, so every stage in between forwards the request untouched. This freedom lets software spread nodes evenly over the stages.

When a leaf is reached the request is marked finished. Its result index then rides unchanged to the output. A separate write port loads node words into any stage while lookups keep flowing.

Top module: `trie_lpm_pipe`

## Requirements
- R1: A lookup accepted at a rising edge with `lk_valid`=1 appears with `res_valid`=1 right after the edge that comes 2·NUM_STAGES−1 edges later. One lookup can be accepted on every edge, with no stall.
- R2: `res_valid` is `lk_valid` delayed by that fixed latency. Input bubbles become output bubbles, and results emerge in acceptance order.
- R3: Traversal starts at word 0 of stage 0 and uses address bits from bit ADDR_W−1 downward, one bit per internal node. A 0 bit selects word `base` and a 1 bit selects word `base+1` (modulo MEM_DEPTH) in the node's named stage.
- R4: A node word is NW = 1 + max(RES_W, SW+MAW) bits wide. The top bit is 1 for a leaf, which holds its result index in bits [RES_W−1:0]. The top bit is 0 for an internal node, which holds the child stage in bits [MAW+SW−1:MAW] and the child base in bits [MAW−1:0].
- R5: When the walk ends at a leaf, the output has `res_found`=1 and `res_index` equal to that leaf's index. `res_found` is 0 whenever `res_valid` is 0.
- R6: A stage not named by a request, or any stage after the leaf has been reached, forwards the request unchanged. This means a child placed several stages after its parent is still found.
- R7: A request whose next node names a stage at or before the current one is never served again. It exits with `res_found`=0 and `res_index`=0.
- R8: A write with `wr_en`=1 stores `wr_data` into word `wr_addr` of stage `wr_stage` only. Writes never stall lookups, and they never alter a lookup that does not read the written word.
- R9: If a write and a lookup read hit the same word at the same edge, the lookup sees the old contents. Later lookups see the new contents.
- R10: While `rst_n` is low, all in-flight requests are dropped. `res_valid` is 0 from the edge after reset until new lookups arrive. Node memory contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | A lookup address is presented |
| lk_addr | input | ADDR_W | Destination address to look up |
| res_valid | output | 1 | A result is presented |
| res_found | output | 1 | The walk ended at a leaf |
| res_index | output | RES_W | Leaf result index, 0 when not found |
| wr_en | input | 1 | Node write strobe |
| wr_stage | input | SW | Stage whose memory is written |
| wr_addr | input | MAW | Word address within that stage |
| wr_data | input | NW | Node word to store |

## Verification
The bench builds the engine with NUM_STAGES=4, MEM_DEPTH=16, RES_W=8 and a 32-bit address. This gives an 8-cycle latency and 9-bit node words. With only four stages, a single trie can skip a stage (stage 0 straight to stage 2), chain through every stage, and point backwards to an earlier stage. It can also be rebuilt through stage 1 at run time. The small depth lets the root word be rewritten at the same edge a lookup reads it. It also lets an unused word be hammered with writes while lookups stream back to back.

// File: rtl/trie_lpm_pkg.sv
// Package: shared definitions for the pipelined trie lookup engine.
// Holds the node kind encoding (top bit of a node word) and a small
// helper used to size the node word from the module parameters.
package trie_lpm_pkg;

    // Kind flag stored in the top bit of every node word.
    typedef enum logic {
        NODE_PTR  = 1'b0,
        NODE_LEAF = 1'b1
    } node_kind_e;

    // Larger of two integers, used for payload sizing.
    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/trie_node_mem.sv
// Module: trie_node_mem
// Private node memory of one stage. Read is synchronous with a one-cycle
// latency. A write and a read of the same word at the same edge return the
// old word (read-before-write). Contents are not reset.
// Assumes: addresses are in range, the caller gates rd_en and wr_en.
module trie_node_mem #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 11,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data
);

    logic [WIDTH-1:0] store [DEPTH];

    // Storage update and registered read; nonblocking gives old data on collision.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_addr] <= wr_data;
        end
        if (rd_en) begin
            rd_data <= store[rd_addr];
        end
    end

endmodule

// File: rtl/trie_stage.sv
// Module: trie_stage
// One pipeline stage, two cycles deep. Cycle A issues a memory read when
// the request targets this stage and is not finished. Cycle B decodes the
// node word: a leaf finishes the request with its index, and an internal
// node picks the child from the current address bit and retargets the
// request. Requests for other stages pass through unchanged.
// Assumes: node word layout as in the brief; the root is handled by the top.
module trie_stage
    import trie_lpm_pkg::*;
#(
    parameter int STAGE_ID  = 0,
    parameter int ADDR_W    = 32,
    parameter int RES_W     = 10,
    parameter int SW        = 3,
    parameter int MAW       = 6,
    parameter int MEM_DEPTH = 64,
    parameter int NW        = 11,
    parameter int BW        = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [BW-1:0]     in_bit,
    input  logic [SW-1:0]     in_tgt,
    input  logic [MAW-1:0]    in_node,
    input  logic              in_done,
    input  logic [RES_W-1:0]  in_res,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [BW-1:0]     out_bit,
    output logic [SW-1:0]     out_tgt,
    output logic [MAW-1:0]    out_node,
    output logic              out_done,
    output logic [RES_W-1:0]  out_res,
    input  logic              wr_en,
    input  logic [MAW-1:0]    wr_addr,
    input  logic [NW-1:0]     wr_data
);

    logic              hit;
    logic [NW-1:0]     rd_data;

    logic              m_valid, m_hit, m_done;
    logic [ADDR_W-1:0] m_addr;
    logic [BW-1:0]     m_bit;
    logic [SW-1:0]     m_tgt;
    logic [MAW-1:0]    m_node;
    logic [RES_W-1:0]  m_res;

    logic [BW-1:0]     n_bit;
    logic [SW-1:0]     n_tgt;
    logic [MAW-1:0]    n_node;
    logic              n_done;
    logic [RES_W-1:0]  n_res;
    node_kind_e        kind;

    // Request owns this stage: live, unfinished and aimed here.
    assign hit = in_valid && !in_done && (in_tgt == SW'(STAGE_ID));

    trie_node_mem #(
        .DEPTH (MEM_DEPTH),
        .WIDTH (NW)
    ) mem_i (
        .clk     (clk),
        .rd_en   (hit),
        .rd_addr (in_node),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    // Cycle A register: hold the request alongside the memory read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_valid <= 1'b0;
            m_hit   <= 1'b0;
            m_addr  <= '0;
            m_bit   <= '0;
            m_tgt   <= '0;
            m_node  <= '0;
            m_done  <= 1'b0;
            m_res   <= '0;
        end else begin
            m_valid <= in_valid;
            m_hit   <= hit;
            m_addr  <= in_addr;
            m_bit   <= in_bit;
            m_tgt   <= in_tgt;
            m_node  <= in_node;
            m_done  <= in_done;
            m_res   <= in_res;
        end
    end

    // Cycle B decode: apply the fetched node, or forward unchanged.
    always_comb begin
        kind   = node_kind_e'(rd_data[NW-1]);
        n_bit  = m_bit;
        n_tgt  = m_tgt;
        n_node = m_node;
        n_done = m_done;
        n_res  = m_res;
        if (m_hit) begin
            if (kind == NODE_LEAF) begin
                n_done = 1'b1;
                n_res  = rd_data[RES_W-1:0];
            end else begin
                n_tgt  = rd_data[MAW+SW-1:MAW];
                n_node = rd_data[MAW-1:0] + {{(MAW-1){1'b0}}, m_addr[m_bit]};
                n_bit  = m_bit - 1'b1;
            end
        end
    end

    // Cycle B register: stage output toward the next stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
            out_bit   <= '0;
            out_tgt   <= '0;
            out_node  <= '0;
            out_done  <= 1'b0;
            out_res   <= '0;
        end else begin
            out_valid <= m_valid;
            out_addr  <= m_addr;
            out_bit   <= n_bit;
            out_tgt   <= n_tgt;
            out_node  <= n_node;
            out_done  <= n_done;
            out_res   <= n_res;
        end
    end

endmodule

// File: rtl/trie_lpm_pipe.sv
// Module: trie_lpm_pipe (top)
// Linear chain of NUM_STAGES trie stages. A new request starts at word 0
// of stage 0 with the address MSB as its next bit. The write port is
// decoded to one stage's memory. Latency is 2*NUM_STAGES cycles.
// Assumes: software places every child in a later stage than its parent.
module trie_lpm_pipe
    import trie_lpm_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int NUM_STAGES = 8,
    parameter int MEM_DEPTH  = 64,
    parameter int RES_W      = 10,
    localparam int SW        = (NUM_STAGES > 1) ? $clog2(NUM_STAGES) : 1,
    localparam int MAW       = (MEM_DEPTH > 1) ? $clog2(MEM_DEPTH) : 1,
    localparam int BW        = $clog2(ADDR_W),
    localparam int PAY_W     = max_int(RES_W, SW + MAW),
    localparam int NW        = PAY_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              res_valid,
    output logic              res_found,
    output logic [RES_W-1:0]  res_index,
    input  logic              wr_en,
    input  logic [SW-1:0]     wr_stage,
    input  logic [MAW-1:0]    wr_addr,
    input  logic [NW-1:0]     wr_data
);

    logic              v_s [NUM_STAGES+1];
    logic [ADDR_W-1:0] a_s [NUM_STAGES+1];
    logic [BW-1:0]     b_s [NUM_STAGES+1];
    logic [SW-1:0]     t_s [NUM_STAGES+1];
    logic [MAW-1:0]    n_s [NUM_STAGES+1];
    logic              d_s [NUM_STAGES+1];
    logic [RES_W-1:0]  r_s [NUM_STAGES+1];
    logic              unused_tail;

    // Entry point: fresh request aimed at the root word.
    assign v_s[0] = lk_valid;
    assign a_s[0] = lk_addr;
    assign b_s[0] = BW'(ADDR_W - 1);
    assign t_s[0] = '0;
    assign n_s[0] = '0;
    assign d_s[0] = 1'b0;
    assign r_s[0] = '0;

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
        logic st_wr;
        // Route the write strobe to this stage only.
        assign st_wr = wr_en && (wr_stage == SW'(g));

        trie_stage #(
            .STAGE_ID  (g),
            .ADDR_W    (ADDR_W),
            .RES_W     (RES_W),
            .SW        (SW),
            .MAW       (MAW),
            .MEM_DEPTH (MEM_DEPTH),
            .NW        (NW),
            .BW        (BW)
        ) stage_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (v_s[g]),
            .in_addr   (a_s[g]),
            .in_bit    (b_s[g]),
            .in_tgt    (t_s[g]),
            .in_node   (n_s[g]),
            .in_done   (d_s[g]),
            .in_res    (r_s[g]),
            .out_valid (v_s[g+1]),
            .out_addr  (a_s[g+1]),
            .out_bit   (b_s[g+1]),
            .out_tgt   (t_s[g+1]),
            .out_node  (n_s[g+1]),
            .out_done  (d_s[g+1]),
            .out_res   (r_s[g+1]),
            .wr_en     (st_wr),
            .wr_addr   (wr_addr),
            .wr_data   (wr_data)
        );
    end

    // Result: only a finished walk reports a hit and an index.
    assign res_valid = v_s[NUM_STAGES];
    assign res_found = v_s[NUM_STAGES] && d_s[NUM_STAGES];
    assign res_index = d_s[NUM_STAGES] ? r_s[NUM_STAGES] : '0;

    // Walk state left over after the last stage has no consumer.
    assign unused_tail = ^{a_s[NUM_STAGES], b_s[NUM_STAGES],
                           t_s[NUM_STAGES], n_s[NUM_STAGES]};

endmodule

// File: rtl/trie_lpm_pipe_chk.sv
// Module: trie_lpm_pipe_chk
// Property checker bound to trie_lpm_pipe. It tracks accepted lookups in
// a LAT-deep shift register so the fixed-latency window needs no deep $past.
module trie_lpm_pipe_chk #(
    parameter int LAT = 16
) (
    input logic clk,
    input logic rst_n,
    input logic lk_valid,
    input logic res_valid,
    input logic res_found
);

    logic [LAT-1:0] acc_q;

    // Record which edges accepted a lookup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= {acc_q[LAT-2:0], lk_valid};
        end
    end

    // R1 and R2: output valid is the input valid after exactly LAT cycles.
    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid == acc_q[LAT-1]);

    // R1: output valid never unknown outside reset.
    assert_known_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(res_valid));

    // R5: a hit is only reported alongside a valid result.
    assert_found_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_found |-> res_valid);

    // R10: reset empties the pipe by the following edge.
    assert_reset_clear_R10: assert property (@(posedge clk)
        !rst_n |=> !res_valid);

endmodule

bind trie_lpm_pipe trie_lpm_pipe_chk #(
    .LAT (2 * NUM_STAGES)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .res_valid (res_valid),
    .res_found (res_found)
);

// File: tb/trie_lpm_pipe_tb_top.sv
// Directed bench for trie_lpm_pipe. A scoreboard slot is written on every
// negative edge and compared LAT negative edges later. Expected results come
// from a bench-side walk of a model memory that follows the requirements.
module trie_lpm_pipe_tb_top;

    localparam int ADDR_W = 32;
    localparam int NS     = 4;
    localparam int DEPTH  = 16;
    localparam int RW     = 8;
    localparam int SW     = 2;
    localparam int MAW    = 4;
    localparam int NW     = 9;
    localparam int LAT    = 2 * NS;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              lk_valid;
    logic [ADDR_W-1:0] lk_addr;
    logic              res_valid, res_found;
    logic [RW-1:0]     res_index;
    logic              wr_en;
    logic [SW-1:0]     wr_stage;
    logic [MAW-1:0]    wr_addr;
    logic [NW-1:0]     wr_data;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    logic [NW-1:0] model [NS][DEPTH];
    logic          ev_v [LAT];
    logic          ev_f [LAT];
    logic [RW-1:0] ev_i [LAT];
    string         ev_t [LAT];

    always #5 clk = ~clk;

    trie_lpm_pipe #(
        .ADDR_W     (ADDR_W),
        .NUM_STAGES (NS),
        .MEM_DEPTH  (DEPTH),
        .RES_W      (RW)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_valid  (lk_valid),
        .lk_addr   (lk_addr),
        .res_valid (res_valid),
        .res_found (res_found),
        .res_index (res_index),
        .wr_en     (wr_en),
        .wr_stage  (wr_stage),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    // R4 encodings: leaf = top bit 1 + index; pointer = top bit 0, stage, base.
    function automatic logic [NW-1:0] leaf(input int idx);
        return {1'b1, RW'(idx)};
    endfunction

    function automatic logic [NW-1:0] ptr(input int st, input int base);
        return {1'b0, 2'b00, SW'(st), MAW'(base)};
    endfunction

    // R3/R6/R7 walk over the model memory.
    task automatic walk(input logic [ADDR_W-1:0] a, output logic f,
                        output logic [RW-1:0] idx);
        int tgt  = 0;
        int node = 0;
        int bitp = ADDR_W - 1;
        logic [NW-1:0] w;
        f = 1'b0;
        idx = '0;
        for (int s = 0; s < NS; s++) begin
            if (!f && tgt == s) begin
                w = model[s][node];
                if (w[NW-1]) begin
                    f = 1'b1;
                    idx = w[RW-1:0];
                end else begin
                    tgt  = int'(w[MAW+SW-1:MAW]);
                    node = (int'(w[MAW-1:0]) + int'(a[bitp])) % DEPTH;
                    bitp = bitp - 1;
                end
            end
        end
    endtask

    function automatic void fail_line(input string tag, input string what,
                                      input int act, input int exp);
        errors++;
        $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    endfunction

    // One cycle: compare the matured slot, then drive new stimulus.
    task automatic tick(input logic v, input logic [ADDR_W-1:0] a,
                        input logic we, input int ws, input int wa,
                        input logic [NW-1:0] wd, input string tag);
        logic f;
        logic [RW-1:0] idx;
        @(negedge clk);
        checks++;
        if (res_valid !== ev_v[LAT-1])
            fail_line(ev_t[LAT-1], "res_valid", int'(res_valid), int'(ev_v[LAT-1]));
        else if (ev_v[LAT-1]) begin
            checks++;
            if (res_found !== ev_f[LAT-1] || res_index !== ev_i[LAT-1])
                fail_line(ev_t[LAT-1], "found/index",
                          int'({res_found, res_index}), int'({ev_f[LAT-1], ev_i[LAT-1]}));
        end else if (res_found !== 1'b0)
            fail_line(ev_t[LAT-1], "res_found idle", int'(res_found), 0);
        for (int k = LAT - 1; k > 0; k--) begin
            ev_v[k] = ev_v[k-1];
            ev_f[k] = ev_f[k-1];
            ev_i[k] = ev_i[k-1];
            ev_t[k] = ev_t[k-1];
        end
        walk(a, f, idx);   // R9: computed before the same-edge write lands
        ev_v[0] = v;
        ev_f[0] = f;
        ev_i[0] = idx;
        ev_t[0] = tag;
        if (we) model[ws][wa] = wd;
        lk_valid = v;
        lk_addr  = a;
        wr_en    = we;
        wr_stage = SW'(ws);
        wr_addr  = MAW'(wa);
        wr_data  = wd;
    endtask

    task automatic clear_board();
        for (int k = 0; k < LAT; k++) begin
            ev_v[k] = 1'b0;
            ev_f[k] = 1'b0;
            ev_i[k] = '0;
            ev_t[k] = "R10";
        end
    endtask

    task automatic flush(input string tag);
        for (int k = 0; k < LAT + 1; k++) tick(1'b0, '0, 1'b0, 0, 0, '0, tag);
    endtask

    task automatic look(input logic [ADDR_W-1:0] a, input string tag);
        tick(1'b1, a, 1'b0, 0, 0, '0, tag);
    endtask

    task automatic put(input int st, input int wa, input logic [NW-1:0] wd);
        tick(1'b0, '0, 1'b1, st, wa, wd, "R8");
    endtask

    // R10: reset state of the outputs.
    task automatic t_reset();
        rst_n = 1'b0;
        lk_valid = 1'b0; lk_addr = '0;
        wr_en = 1'b0; wr_stage = '0; wr_addr = '0; wr_data = '0;
        clear_board();
        repeat (2) @(negedge clk);
        checks++;
        if (res_valid !== 1'b0 || res_found !== 1'b0)
            fail_line("R10", "reset outputs", int'({res_valid, res_found}), 0);
        rst_n = 1'b1;
    endtask

    // R4/R8: load the trie through the write port.
    task automatic t_load();
        for (int s = 0; s < NS; s++)
            for (int w = 0; w < DEPTH; w++) model[s][w] = '0;
        put(0, 0, ptr(2, 4));
        put(2, 4, leaf(8'h11));
        put(2, 5, ptr(3, 2));
        put(3, 2, leaf(8'h22));
        put(3, 3, ptr(1, 0));
        put(1, 6, leaf(8'h33));
        put(1, 7, ptr(3, 8));
        put(3, 8, leaf(8'h44));
        put(3, 9, leaf(8'h55));
        flush("R8");
    endtask

    // R3/R5/R6: stage skip (0 to 2), chain to stage 3, back-to-back input.
    task automatic t_basic();
        look(32'h0000_0000, "R6");
        look(32'h7FFF_FFFF, "R3");
        look(32'h8000_0000, "R5");
        look(32'hBFFF_FFFF, "R3");
        flush("R1");
    endtask

    // R7: pointer back to an earlier stage yields a miss.
    task automatic t_miss();
        look(32'hC000_0000, "R7");
        look(32'hFFFF_FFFF, "R7");
        flush("R7");
    endtask

    // R2: bubbles between lookups are preserved in order.
    task automatic t_bubbles();
        look(32'h8000_0000, "R2");
        tick(1'b0, '0, 1'b0, 0, 0, '0, "R2");
        look(32'h1234_5678, "R2");
        tick(1'b0, '0, 1'b0, 0, 0, '0, "R2");
        tick(1'b0, '0, 1'b0, 0, 0, '0, "R2");
        look(32'hC000_0000, "R2");
        flush("R2");
    endtask

    // R9: root rewritten at the edge a lookup reads it.
    task automatic t_collide();
        tick(1'b1, 32'h8000_0000, 1'b1, 0, 0, ptr(1, 6), "R9");
        look(32'h8000_0000, "R9");
        look(32'h4000_0000, "R9");
        look(32'hC000_0000, "R9");
        flush("R9");
    endtask

    // R8: writes to an unused word every cycle while lookups stream.
    task automatic t_stream_write();
        for (int k = 0; k < 12; k++)
            tick(1'b1, (k % 3 == 0) ? 32'h0 : ((k % 3 == 1) ? 32'h8000_0000 : 32'hC000_0000),
                 1'b1, 2, 12, leaf(k), "R8");
        flush("R8");
    endtask

    // R10: reset in flight drops pending lookups, memory survives.
    task automatic t_midreset();
        look(32'h4000_0000, "R10");
        look(32'h8000_0000, "R10");
        @(negedge clk);
        rst_n = 1'b0;
        lk_valid = 1'b0;
        wr_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        clear_board();
        flush("R10");
        look(32'h4000_0000, "R10");
        flush("R10");
    endtask

    initial begin
        t_reset();
        t_load();
        t_basic();
        t_miss();
        t_bubbles();
        t_collide();
        t_stream_write();
        t_midreset();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule